// File: doc/BRIEF.md
# Locked Enhanced Register Bank

This block holds the control registers that sit beside a UART's extended functions: a feature-control register, four character-match registers (two "resume" and two "pause" characters for software flow control), a scratch byte, and the interrupt-enable, FIFO-control and modem-control registers. The feature-control register and the four character registers share host addresses with the ordinary registers. They are reachable only while the line control value presented by the rest of the UART equals a magic key (0xBF by default). At any other line control value, the same addresses reach the ordinary registers.

Bit 4 of the feature-control register is an unlock bit. While it is clear, the upper fields of the interrupt-enable, interrupt-identification, FIFO-control and modem-control registers are frozen, so legacy software cannot change them. While it is set, those fields follow host writes. In the same way, the upper bits of the interrupt-identification code either follow the datapath or hold. All register contents are driven out to the datapath. The block performs no flow-control actions itself.

Top module: `ehr_bank`

## Requirements
- R1: After reset every register is 0, so the block starts locked (enh_unlock_o = 0), and every output reads 0.
- R2: With lcr_i = 0xBF, a write to address 2 loads the feature register, and writes to addresses 4, 5, 6 and 7 load resume-1, resume-2, pause-1 and pause-2. A read at these addresses returns the stored byte. Bit 0 of each character register is the character's LSB.
- R3: With lcr_i other than 0xBF, no host access reaches the feature or character registers. Address 1 is interrupt-enable, address 2 is FIFO-control on write and interrupt-identification on read, address 4 is modem-control, and address 7 is scratch.
- R4: While locked, writes leave interrupt-enable bits 7:4, FIFO-control bits 5:4 and modem-control bits 7:5 unchanged.
- R5: While unlocked, writes replace all bits of these three registers.
- R6: Interrupt-enable bits 3:0, FIFO-control bits 7:6 and 3:0, and modem-control bits 4:0 take the written value whatever the lock state.
- R7: int_id_o is {upper, irq_id_i[3:0]}. The 2-bit upper field loads irq_id_i[5:4] on each clock while unlocked and holds while locked. A read at address 2 in normal mode returns {2'b00, int_id_o}.
- R8: The scratch register at address 7 in normal mode stores and returns any byte and drives no other output.
- R9: tx_flow_o = feature[3:2], rx_flow_o = feature[1:0], enh_unlock_o = feature[4] and spec_det_en_o = feature[5].
- R10: rdata_o is 0 when rd_en_i is low, and at unmapped addresses (0 and 3 in either mode, 1 in key mode, 5 and 6 in normal mode).

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| addr_i | input | 3 | Register address |
| wdata_i | input | 8 | Write data |
| wr_en_i | input | 1 | Write strobe |
| rd_en_i | input | 1 | Read strobe |
| lcr_i | input | 8 | Current line control value |
| irq_id_i | input | 6 | Interrupt code from datapath |
| rdata_o | output | 8 | Read data (combinational) |
| efr_o | output | 8 | Feature register |
| tx_flow_o | output | 2 | Transmit flow-control mode |
| rx_flow_o | output | 2 | Receive compare mode |
| enh_unlock_o | output | 1 | Protected fields writable |
| spec_det_en_o | output | 1 | Special-character detect enable |
| xon1_o | output | 8 | Resume character 1 |
| xon2_o | output | 8 | Resume character 2 |
| xoff1_o | output | 8 | Pause character 1 |
| xoff2_o | output | 8 | Pause character 2 |
| ier_o | output | 8 | Interrupt-enable register |
| fcr_o | output | 8 | FIFO-control register |
| mcr_o | output | 8 | Modem-control register |
| int_id_o | output | 6 | Interrupt code seen by the host |

## Verification
A wrong lock state appears on enh_unlock_o at once. One cycle after the next write to a protected field, the wrong state also shows on ier_o, fcr_o or mcr_o. A decode error that lets a normal-mode write reach the hidden bank changes efr_o or a character output on the next clock. Comparing every output on every cycle therefore exposes such a fault within one cycle of the access that triggers it. A stale interrupt-identification upper field appears on int_id_o in the cycle after irq_id_i changes while unlocked.

// File: rtl/ehr_pkg.sv
package ehr_pkg;
   localparam int DW     = 8;
   localparam int N_CHAR = 4;

   typedef enum logic [2:0] {
      SEL_NONE,
      SEL_IER,
      SEL_ISR,
      SEL_MCR,
      SEL_SCR,
      SEL_EFR
   } sel_e;

   typedef struct packed {
      logic              ier;
      logic              fcr;
      logic              mcr;
      logic              scr;
      logic              efr;
      logic [N_CHAR-1:0] chr;
   } wr_t;
endpackage

// File: rtl/ehr_reg.sv
module ehr_reg #(
   parameter int           W    = 8,
   parameter logic [W-1:0] PROT = '0
) (
   input  logic         clk,
   input  logic         rst_n,
   input  logic         we,
   input  logic         unlock,
   input  logic [W-1:0] wd,
   output logic [W-1:0] q
);
   always_ff @(posedge clk) begin
      if (!rst_n)
         q <= '0;
      else if (we)
         q <= unlock ? wd : ((wd & ~PROT) | (q & PROT));
   end

   generate
      if (PROT != '0) begin : g_prot_chk
         p_prot_hold_r4: assert property (@(posedge clk) disable iff (!rst_n)
            !unlock |=> ((q & PROT) == ($past(q) & PROT)))
            else $error("protected field changed while locked");
         p_full_write_r5: assert property (@(posedge clk) disable iff (!rst_n)
            (we && unlock) |=> (q == $past(wd)))
            else $error("unlocked write not taken");
      end
   endgenerate

   p_open_write_r6: assert property (@(posedge clk) disable iff (!rst_n)
      we |=> ((q & ~PROT) == ($past(wd) & ~PROT)))
      else $error("unprotected field write lost");
endmodule

// File: rtl/ehr_decode.sv
module ehr_decode
   import ehr_pkg::*;
#(
   parameter int         ADDR_W  = 3,
   parameter logic [7:0] MAGIC   = 8'hBF,
   parameter int         A_IER   = 1,
   parameter int         A_ISR   = 2,
   parameter int         A_MCR   = 4,
   parameter int         A_SCR   = 7,
   parameter int         A_EFR   = 2,
   parameter int         A_CHAR0 = 4
) (
   input  logic [ADDR_W-1:0] addr,
   input  logic [7:0]        lcr,
   input  logic              wr_en,
   output sel_e              sel,
   output logic [N_CHAR-1:0] chr_hit,
   output wr_t               wr
);
   logic key;

   always_comb begin
      key     = (lcr == MAGIC);
      sel     = SEL_NONE;
      chr_hit = '0;
      if (key) begin
         if (addr == ADDR_W'(A_EFR)) sel = SEL_EFR;
         for (int k = 0; k < N_CHAR; k++)
            chr_hit[k] = (addr == ADDR_W'(A_CHAR0 + k));
      end else begin
         if (addr == ADDR_W'(A_IER))      sel = SEL_IER;
         else if (addr == ADDR_W'(A_ISR)) sel = SEL_ISR;
         else if (addr == ADDR_W'(A_MCR)) sel = SEL_MCR;
         else if (addr == ADDR_W'(A_SCR)) sel = SEL_SCR;
      end
      wr.ier = wr_en && (sel == SEL_IER);
      wr.fcr = wr_en && (sel == SEL_ISR);
      wr.mcr = wr_en && (sel == SEL_MCR);
      wr.scr = wr_en && (sel == SEL_SCR);
      wr.efr = wr_en && (sel == SEL_EFR);
      wr.chr = wr_en ? chr_hit : '0;
   end
endmodule

// File: rtl/ehr_bank.sv
module ehr_bank
   import ehr_pkg::*;
#(
   parameter int         ADDR_W  = 3,
   parameter logic [7:0] MAGIC   = 8'hBF,
   parameter int         A_IER   = 1,
   parameter int         A_ISR   = 2,
   parameter int         A_MCR   = 4,
   parameter int         A_SCR   = 7,
   parameter int         A_EFR   = 2,
   parameter int         A_CHAR0 = 4,
   parameter int         UNLOCK_BIT = 4
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic [ADDR_W-1:0] addr_i,
   input  logic [7:0]        wdata_i,
   input  logic              wr_en_i,
   input  logic              rd_en_i,
   input  logic [7:0]        lcr_i,
   input  logic [5:0]        irq_id_i,
   output logic [7:0]        rdata_o,
   output logic [7:0]        efr_o,
   output logic [1:0]        tx_flow_o,
   output logic [1:0]        rx_flow_o,
   output logic              enh_unlock_o,
   output logic              spec_det_en_o,
   output logic [7:0]        xon1_o,
   output logic [7:0]        xon2_o,
   output logic [7:0]        xoff1_o,
   output logic [7:0]        xoff2_o,
   output logic [7:0]        ier_o,
   output logic [7:0]        fcr_o,
   output logic [7:0]        mcr_o,
   output logic [5:0]        int_id_o
);
   localparam int          N_ADDR    = 2 ** ADDR_W;
   localparam logic [7:0]  IER_PROT  = 8'hF0;
   localparam logic [7:0]  FCR_PROT  = 8'h30;
   localparam logic [7:0]  MCR_PROT  = 8'hE0;

   initial begin
      chk_addr_w: assert (ADDR_W >= 3);
      chk_chars:  assert (A_CHAR0 + N_CHAR <= N_ADDR);
      chk_efr:    assert (A_EFR < A_CHAR0);
      chk_bit:    assert (UNLOCK_BIT < DW);
   end

   sel_e              sel;
   logic [N_CHAR-1:0] chr_hit;
   wr_t               wr;
   logic              unlock;
   logic [7:0]        scr_q;
   logic [1:0]        isr_hi_q;
   logic [7:0]        chr_q [N_CHAR];
   logic [7:0]        chr_rd;

   ehr_decode #(
      .ADDR_W(ADDR_W), .MAGIC(MAGIC), .A_IER(A_IER), .A_ISR(A_ISR),
      .A_MCR(A_MCR), .A_SCR(A_SCR), .A_EFR(A_EFR), .A_CHAR0(A_CHAR0)
   ) dec_i (
      .addr(addr_i), .lcr(lcr_i), .wr_en(wr_en_i),
      .sel(sel), .chr_hit(chr_hit), .wr(wr)
   );

   assign unlock = efr_o[UNLOCK_BIT];

   ehr_reg #(.W(8), .PROT('0)) efr_i (
      .clk(clk), .rst_n(rst_n), .we(wr.efr), .unlock(1'b1),
      .wd(wdata_i), .q(efr_o));
   ehr_reg #(.W(8), .PROT(IER_PROT)) ier_i (
      .clk(clk), .rst_n(rst_n), .we(wr.ier), .unlock(unlock),
      .wd(wdata_i), .q(ier_o));
   ehr_reg #(.W(8), .PROT(FCR_PROT)) fcr_i (
      .clk(clk), .rst_n(rst_n), .we(wr.fcr), .unlock(unlock),
      .wd(wdata_i), .q(fcr_o));
   ehr_reg #(.W(8), .PROT(MCR_PROT)) mcr_i (
      .clk(clk), .rst_n(rst_n), .we(wr.mcr), .unlock(unlock),
      .wd(wdata_i), .q(mcr_o));
   ehr_reg #(.W(8), .PROT('0)) scr_i (
      .clk(clk), .rst_n(rst_n), .we(wr.scr), .unlock(1'b1),
      .wd(wdata_i), .q(scr_q));

   generate
      for (genvar g = 0; g < N_CHAR; g++) begin : g_chr
         ehr_reg #(.W(8), .PROT('0)) chr_i (
            .clk(clk), .rst_n(rst_n), .we(wr.chr[g]), .unlock(1'b1),
            .wd(wdata_i), .q(chr_q[g]));
      end
   endgenerate

   always_ff @(posedge clk) begin
      if (!rst_n)
         isr_hi_q <= '0;
      else if (unlock)
         isr_hi_q <= irq_id_i[5:4];
   end

   assign int_id_o      = {isr_hi_q, irq_id_i[3:0]};
   assign xon1_o        = chr_q[0];
   assign xon2_o        = chr_q[1];
   assign xoff1_o       = chr_q[2];
   assign xoff2_o       = chr_q[3];
   assign tx_flow_o     = efr_o[3:2];
   assign rx_flow_o     = efr_o[1:0];
   assign enh_unlock_o  = unlock;
   assign spec_det_en_o = efr_o[5];

   always_comb begin
      chr_rd = '0;
      for (int k = 0; k < N_CHAR; k++)
         if (chr_hit[k]) chr_rd = chr_q[k];
   end

   always_comb begin
      rdata_o = '0;
      if (rd_en_i) begin
         unique case (sel)
            SEL_IER:  rdata_o = ier_o;
            SEL_ISR:  rdata_o = {2'b00, int_id_o};
            SEL_MCR:  rdata_o = mcr_o;
            SEL_SCR:  rdata_o = scr_q;
            SEL_EFR:  rdata_o = efr_o;
            default:  rdata_o = chr_rd;
         endcase
      end
   end

   p_hidden_bank_r3: assert property (@(posedge clk) disable iff (!rst_n)
      (lcr_i != MAGIC) |=> ($stable(efr_o) && $stable(xon1_o) && $stable(xon2_o)
                            && $stable(xoff1_o) && $stable(xoff2_o)))
      else $error("key-only register changed outside key mode");
   p_normal_hidden_r2: assert property (@(posedge clk) disable iff (!rst_n)
      (lcr_i == MAGIC) |=> ($stable(ier_o) && $stable(fcr_o) && $stable(mcr_o)))
      else $error("normal register changed in key mode");
   p_isr_hold_r7: assert property (@(posedge clk) disable iff (!rst_n)
      !enh_unlock_o |=> $stable(int_id_o[5:4]))
      else $error("interrupt upper field moved while locked");
   p_rd_quiet_r10: assert property (@(posedge clk) disable iff (!rst_n)
      !rd_en_i |-> (rdata_o == 8'h00))
      else $error("read data without read strobe");
endmodule

// File: tb/ehr_bank_tb.sv
module ehr_bank_tb_top;
   logic       clk = 1'b0;
   logic       rst_n = 1'b0;
   logic [2:0] addr = '0;
   logic [7:0] wdata = '0;
   logic       wr_en = 1'b0;
   logic       rd_en = 1'b0;
   logic [7:0] lcr = 8'h03;
   logic [5:0] irq = '0;

   logic [7:0] rdata, efr, xon1, xon2, xoff1, xoff2, ier, fcr, mcr;
   logic [1:0] txf, rxf;
   logic       unl, sde;
   logic [5:0] iid;

   always #10 clk = ~clk;

   ehr_bank dut_i (
      .clk(clk), .rst_n(rst_n), .addr_i(addr), .wdata_i(wdata),
      .wr_en_i(wr_en), .rd_en_i(rd_en), .lcr_i(lcr), .irq_id_i(irq),
      .rdata_o(rdata), .efr_o(efr), .tx_flow_o(txf), .rx_flow_o(rxf),
      .enh_unlock_o(unl), .spec_det_en_o(sde), .xon1_o(xon1), .xon2_o(xon2),
      .xoff1_o(xoff1), .xoff2_o(xoff2), .ier_o(ier), .fcr_o(fcr),
      .mcr_o(mcr), .int_id_o(iid));

   // behavioural reference state
   logic [7:0] m_ier, m_fcr, m_mcr, m_scr, m_efr;
   logic [7:0] m_ch [4];
   logic [1:0] m_hi;
   int n_chk = 0;
   int n_fail = 0;
   bit done = 0;

   always @(posedge clk) begin
      if (!rst_n) begin
         m_ier <= 0; m_fcr <= 0; m_mcr <= 0; m_scr <= 0; m_efr <= 0; m_hi <= 0;
         for (int k = 0; k < 4; k++) m_ch[k] <= 0;
      end else begin
         if (m_efr[4]) m_hi <= irq[5:4];
         if (wr_en) begin
            if (lcr == 8'hBF) begin
               if (addr == 2) m_efr <= wdata;
               if (addr >= 4) m_ch[addr - 4] <= wdata;
            end else begin
               case (addr)
                  1: m_ier <= m_efr[4] ? wdata : {m_ier[7:4], wdata[3:0]};
                  2: m_fcr <= m_efr[4] ? wdata : {wdata[7:6], m_fcr[5:4], wdata[3:0]};
                  4: m_mcr <= m_efr[4] ? wdata : {m_mcr[7:5], wdata[4:0]};
                  7: m_scr <= wdata;
                  default: ;
               endcase
            end
         end
      end
   end

   function automatic logic [7:0] exp_rd();
      if (!rd_en) return 8'h00;
      if (lcr == 8'hBF) begin
         if (addr == 2) return m_efr;
         if (addr >= 4) return m_ch[addr - 4];
         return 8'h00;
      end
      case (addr)
         1: return m_ier;
         2: return {2'b00, m_hi, irq[3:0]};
         4: return m_mcr;
         7: return m_scr;
         default: return 8'h00;
      endcase
   endfunction

   task automatic chk(input string req, input string what, input logic [7:0] act, input logic [7:0] exp);
      n_chk++;
      if (act !== exp) begin
         n_fail++;
         $display("FAIL %s %s actual=%02h expected=%02h", req, what, act, exp);
      end
   endtask

   // compares all outputs against the model; called away from the edge
   task automatic compare_all();
      chk("R2", "efr", efr, m_efr);
      chk("R2", "xon1", xon1, m_ch[0]);
      chk("R2", "xon2", xon2, m_ch[1]);
      chk("R2", "xoff1", xoff1, m_ch[2]);
      chk("R2", "xoff2", xoff2, m_ch[3]);
      chk("R4", "ier", ier, m_ier);
      chk("R4", "fcr", fcr, m_fcr);
      chk("R6", "mcr", mcr, m_mcr);
      chk("R7", "int_id", {2'b00, iid}, {2'b00, m_hi, irq[3:0]});
      chk("R9", "flow", {txf, rxf, unl, sde, 2'b00},
          {m_efr[3:2], m_efr[1:0], m_efr[4], m_efr[5], 2'b00});
      chk("R10", "rdata", rdata, exp_rd());
   endtask

   task automatic step(input logic [7:0] l, input logic [2:0] a, input logic w,
                       input logic r, input logic [7:0] d);
      @(negedge clk);
      lcr = l; addr = a; wr_en = w; rd_en = r; wdata = d;
      #1 compare_all();
   endtask

   task automatic wr(input logic [7:0] l, input logic [2:0] a, input logic [7:0] d);
      step(l, a, 1'b1, 1'b0, d);
   endtask

   task automatic rd(input logic [7:0] l, input logic [2:0] a);
      step(l, a, 1'b0, 1'b1, 8'h00);
   endtask

   task automatic finish_run();
      if (!done) begin
         done = 1;
         $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
         $finish;
      end
   endtask

   initial begin
      repeat (50000) @(posedge clk);
      n_chk++; n_fail++;
      $display("FAIL watchdog expired actual=running expected=finished");
      finish_run();
   end

   initial begin
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      // R1: reset state, all outputs zero and locked
      #1 compare_all();
      chk("R1", "unlock after reset", {7'd0, unl}, 8'h00);
      // R4/R6: locked writes touch only low fields
      wr(8'h03, 1, 8'hFF); wr(8'h03, 2, 8'hFF); wr(8'h03, 4, 8'hFF);
      irq = 6'h3A;
      rd(8'h03, 1); rd(8'h03, 2); rd(8'h03, 4);
      chk("R4", "ier locked", ier, 8'h0F);
      chk("R4", "fcr locked", fcr, 8'hCF);
      chk("R6", "mcr low", mcr, 8'h1F);
      chk("R7", "int_id held", {2'b00, iid}, 8'h0A);
      // R8: scratch
      wr(8'h03, 7, 8'hA5); rd(8'h03, 7);
      chk("R8", "scratch", rdata, 8'hA5);
      // R2: key mode bank
      wr(8'hBF, 2, 8'h1B); wr(8'hBF, 4, 8'h11); wr(8'hBF, 5, 8'h12);
      wr(8'hBF, 6, 8'h13); wr(8'hBF, 7, 8'h93);
      rd(8'hBF, 2); rd(8'hBF, 5); rd(8'hBF, 7);
      chk("R2", "xoff2 read", rdata, 8'h93);
      rd(8'hBF, 1); rd(8'hBF, 0); rd(8'hBF, 3);
      chk("R10", "unmapped key read", rdata, 8'h00);
      wr(8'hBF, 1, 8'h77);
      chk("R9", "unlock bit", {7'd0, unl}, 8'h01);
      // R3: normal mode address 2 hits FCR, not EFR
      wr(8'h03, 2, 8'hFF); rd(8'h03, 7); rd(8'h03, 5); rd(8'h03, 6);
      chk("R3", "efr untouched", efr, 8'h1B);
      chk("R5", "fcr unlocked", fcr, 8'hFF);
      chk("R3", "scratch not char", rdata, 8'h00);
      // R5: unlocked full writes; R7 follows irq
      wr(8'h03, 1, 8'hC3); wr(8'h03, 4, 8'hE0);
      irq = 6'h25; rd(8'h03, 2); rd(8'h03, 2);
      chk("R7", "int_id follows", rdata, 8'h25);
      chk("R5", "ier unlocked", ier, 8'hC3);
      // relock with special detect, R9 decode
      wr(8'hBF, 2, 8'h2B);
      wr(8'h03, 1, 8'h05); wr(8'h03, 4, 8'h00);
      irq = 6'h10; rd(8'h03, 2);
      chk("R4", "ier relocked", ier, 8'hC5);
      chk("R4", "mcr relocked", mcr, 8'hE0);
      chk("R9", "spec detect", {7'd0, sde}, 8'h01);
      // mixed traffic
      for (int i = 0; i < 400; i++) begin
         irq = 6'($urandom);
         step(($urandom % 3 == 0) ? 8'hBF : 8'($urandom), 3'($urandom),
              1'($urandom), 1'($urandom), 8'($urandom));
      end
      // R1: reset again mid-run
      @(negedge clk); rst_n = 1'b0; wr_en = 0; rd_en = 0;
      @(negedge clk); rst_n = 1'b1;
      #1 compare_all();
      chk("R1", "efr after reset", efr, 8'h00);
      @(negedge clk);
      finish_run();
   end
endmodule